// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Steering Controller

This block drives the external bus of a 16-bit microcontroller whose address and data share the same two 8-bit pin groups, an upper lane and a lower lane. Each access is split by an enable strobe: while the strobe is high both lanes present the address and an address-latch-enable pulse lets an external latch capture it. While the strobe is low the lanes move data. Which lane carries which byte depends on a bus-width pin (low means a 16-bit bus, high means an 8-bit bus). On an 8-bit bus a word access takes two address/data pairs.

The controller accepts one request at a time from the core side. The request gives the direction, word or byte size, address, write data and a flag that marks internal memory. The controller works out the effective bus width. Two fixed register addresses are always handled as 16-bit internal cycles. An optional strap forces the 16-bit width for a ROM address window. On a read of internal memory the internal data replaces whatever the pins carry. Read results come back one cycle after the last data phase.

The sequencer has five states. ST_IDLE returns to itself, or goes to ST_ADDR when a request is accepted. ST_ADDR is the address phase, ST_DATA the first data phase, ST_ADDR2 the second address phase and ST_DATA2 the second data phase. The transitions are:
- ST_ADDR goes to ST_DATA.
- ST_DATA goes to ST_ADDR2 for a word access on the 8-bit bus, and to ST_IDLE otherwise.
- ST_ADDR2 goes to ST_DATA2.
- ST_DATA2 goes to ST_IDLE.

Top module: `muxbus_steer`

## Requirements
- R1: During and right after reset the controller is idle: `ale`=0, `e_strobe`=1, `busy`=0, both lane output enables are 0, `rd_valid`=0 and `addr_latched`=0.
- R2: A request seen in ST_IDLE starts ST_ADDR on the next cycle. In ST_ADDR and ST_ADDR2: `ale`=1, `e_strobe`=1, both lanes enabled, upper lane = address bits 15:8, lower lane = bits 7:0. In ST_DATA and ST_DATA2: `ale`=0 and `e_strobe`=0. `busy` is 1 in every state except ST_IDLE. A request raised while busy is ignored, and so are changes to request fields after acceptance.
- R3: `addr_latched` follows the lane address while `ale`=1 and holds the last such value while `ale`=0.
- R4: On the 16-bit bus in a write data phase, the lower lane carries the even byte and the upper lane carries the odd byte. A word write drives data bits 7:0 on the lower lane and bits 15:8 on the upper lane, with both lanes enabled. A byte write drives data bits 7:0 only on the lane selected by address bit 0 (1 = upper) and leaves the other lane disabled.
- R5: On the 8-bit bus in a write data phase, the byte always goes on the lower lane. When the current address is odd, the same byte is also driven on the upper lane; when it is even, the upper lane stays disabled.
- R6: A word access on the 8-bit bus runs two address/data pairs. The first uses the even address and moves data bits 7:0. The second uses the even address plus one and moves bits 15:8. A read assembles the two bytes in that order.
- R7: In read data phases both lane enables are 0. `rd_valid` is 1 for exactly one cycle, the cycle after the last data phase, with `rd_data` valid. Byte reads are zero-extended. On the 16-bit bus a byte read takes the lane selected by address bit 0; on the 8-bit bus it takes the lower lane.
- R8: When the request marks internal memory, a read returns `int_rdata` and ignores the lane inputs. Word reads return it whole. Byte reads return bits 15:8 for odd addresses and bits 7:0 for even ones. The bus cycle itself still runs.
- R9: Addresses 0x000A/0x000B and 0x000C/0x000D are always handled as 16-bit and internal, whatever the bus-width pin and the internal flag say.
- R10: With `rom16_strap`=1, addresses 0xC000 to 0xEFFF use the 16-bit bus even when the bus-width pin is high. Lane data is still used. With the strap low the pin decides.
- R11: For word accesses address bit 0 is ignored: the address phase presents the address with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request an access (taken only when not busy) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| req_int | input | 1 | Access targets internal memory |
| int_rdata | input | 16 | Internal memory read data |
| width8_pin | input | 1 | Bus-width pin: 1 = 8-bit bus, 0 = 16-bit bus |
| rom16_strap | input | 1 | Force 16-bit width in the ROM window |
| ale | output | 1 | Address latch enable |
| e_strobe | output | 1 | Phase strobe: 1 = address/idle, 0 = data |
| hi_out | output | 8 | Upper lane output value |
| hi_oe | output | 1 | Upper lane output enable |
| hi_in | input | 8 | Upper lane input value |
| lo_out | output | 8 | Lower lane output value |
| lo_oe | output | 1 | Lower lane output enable |
| lo_in | input | 8 | Lower lane input value |
| addr_latched | output | 16 | Output of the address latch model |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 16 | Read result |

## Verification
The embedded assertions check, on every cycle:
- that lane drivers stay off in any read data phase;
- that the latch holds while its enable is low;
- that a read strobe never lasts two cycles;
- that a second address phase only follows a first data phase;
- that ST_DATA falls back to ST_IDLE unless two beats are due;
- that the fixed register addresses always come out wide and internal.

Only the bench scenarios can show whether each byte lands on the right lane for every width, size and parity. The same holds for the assembled read value, the internal-data override, the effect of the ROM strap, and whether a request raised mid-access really has no effect.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DATA  = 3'd2,
        ST_ADDR2 = 3'd3,
        ST_DATA2 = 3'd4
    } bus_state_t;

endpackage

// File: rtl/muxbus_width_decode.sv
module muxbus_width_decode #(
    parameter int unsigned AW       = 16,
    parameter int unsigned SPEC_A   = 'h000A,
    parameter int unsigned SPEC_B   = 'h000C,
    parameter int unsigned ROM_BASE = 'hC000,
    parameter int unsigned ROM_LAST = 'hEFFF
) (
    input  logic [AW-1:0] addr,
    input  logic          width8_pin,
    input  logic          rom16_strap,
    input  logic          int_flag,
    output logic          wide,
    output logic          internal,
    output logic          special
);

    localparam logic [AW-1:0] SA = AW'(SPEC_A);
    localparam logic [AW-1:0] SB = AW'(SPEC_B);
    localparam logic [AW-1:0] RB = AW'(ROM_BASE);
    localparam logic [AW-1:0] RL = AW'(ROM_LAST);

    logic in_rom;

    always_comb begin
        special  = (addr[AW-1:1] == SA[AW-1:1]) || (addr[AW-1:1] == SB[AW-1:1]);
        in_rom   = rom16_strap && (addr >= RB) && (addr <= RL);
        wide     = !width8_pin || special || in_rom;
        internal = int_flag || special;
    end

endmodule

// File: rtl/muxbus_fsm.sv
module muxbus_fsm
    import muxbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic two_beat,
    output logic ale,
    output logic e_strobe,
    output logic busy,
    output logic addr_phase,
    output logic data_phase,
    output logic second,
    output logic last_data
);

    bus_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_ADDR;
            ST_ADDR:  state_nx = ST_DATA;
            ST_DATA:  state_nx = two_beat ? ST_ADDR2 : ST_IDLE;
            ST_ADDR2: state_nx = ST_DATA2;
            ST_DATA2: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ale        = 1'b0;
        e_strobe   = 1'b1;
        busy       = 1'b1;
        addr_phase = 1'b0;
        data_phase = 1'b0;
        second     = 1'b0;
        last_data  = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_ADDR: begin
                ale        = 1'b1;
                addr_phase = 1'b1;
            end
            ST_DATA: begin
                e_strobe   = 1'b0;
                data_phase = 1'b1;
                last_data  = !two_beat;
            end
            ST_ADDR2: begin
                ale        = 1'b1;
                addr_phase = 1'b1;
                second     = 1'b1;
            end
            ST_DATA2: begin
                e_strobe   = 1'b0;
                data_phase = 1'b1;
                second     = 1'b1;
                last_data  = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    assert_addr2_follows_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR2) |-> ($past(state) == ST_DATA));

    assert_single_beat_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !two_beat) |=> (state == ST_IDLE));

endmodule

// File: rtl/muxbus_lane_steer.sv
module muxbus_lane_steer #(
    parameter int unsigned LANE_W = 8
) (
    input  logic                addr_phase,
    input  logic                data_phase,
    input  logic                second,
    input  logic                we,
    input  logic                word,
    input  logic                wide,
    input  logic [2*LANE_W-1:0] addr,
    input  logic [2*LANE_W-1:0] wdata,
    output logic [2*LANE_W-1:0] cur_addr,
    output logic [LANE_W-1:0]   hi_out,
    output logic                hi_oe,
    output logic [LANE_W-1:0]   lo_out,
    output logic                lo_oe
);

    localparam int unsigned AW = 2 * LANE_W;

    logic [LANE_W-1:0] nbyte;

    always_comb begin
        cur_addr = second ? (addr | AW'(1)) : addr;
        nbyte    = (word && second) ? wdata[AW-1:LANE_W] : wdata[LANE_W-1:0];
        hi_out   = '0;
        lo_out   = '0;
        hi_oe    = 1'b0;
        lo_oe    = 1'b0;
        if (addr_phase) begin
            hi_out = cur_addr[AW-1:LANE_W];
            lo_out = cur_addr[LANE_W-1:0];
            hi_oe  = 1'b1;
            lo_oe  = 1'b1;
        end else if (data_phase && we) begin
            if (wide) begin
                if (word) begin
                    hi_out = wdata[AW-1:LANE_W];
                    lo_out = wdata[LANE_W-1:0];
                    hi_oe  = 1'b1;
                    lo_oe  = 1'b1;
                end else if (cur_addr[0]) begin
                    hi_out = wdata[LANE_W-1:0];
                    hi_oe  = 1'b1;
                end else begin
                    lo_out = wdata[LANE_W-1:0];
                    lo_oe  = 1'b1;
                end
            end else begin
                lo_out = nbyte;
                lo_oe  = 1'b1;
                if (cur_addr[0]) begin
                    hi_out = nbyte;
                    hi_oe  = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/muxbus_rd_capture.sv
module muxbus_rd_capture #(
    parameter int unsigned LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                finish,
    input  logic                second,
    input  logic                word,
    input  logic                wide,
    input  logic                internal,
    input  logic                odd,
    input  logic [LANE_W-1:0]   hi_in,
    input  logic [LANE_W-1:0]   lo_in,
    input  logic [2*LANE_W-1:0] int_rdata,
    output logic [2*LANE_W-1:0] rd_data,
    output logic                rd_valid
);

    localparam int unsigned AW = 2 * LANE_W;

    logic [LANE_W-1:0] src_hi, src_lo, nbyte;

    always_comb begin
        src_hi = internal ? int_rdata[AW-1:LANE_W] : hi_in;
        src_lo = internal ? int_rdata[LANE_W-1:0]  : lo_in;
        nbyte  = internal ? (odd ? int_rdata[AW-1:LANE_W] : int_rdata[LANE_W-1:0]) : lo_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= finish;
            if (capture) begin
                if (wide && word)       rd_data <= {src_hi, src_lo};
                else if (wide)          rd_data <= {{LANE_W{1'b0}}, odd ? src_hi : src_lo};
                else if (!word)         rd_data <= {{LANE_W{1'b0}}, nbyte};
                else if (second)        rd_data[AW-1:LANE_W] <= nbyte;
                else                    rd_data <= {{LANE_W{1'b0}}, nbyte};
            end
        end
    end

    assert_rd_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/muxbus_steer.sv
module muxbus_steer #(
    parameter int unsigned LANE_W   = 8,
    parameter int unsigned SPEC_A   = 'h000A,
    parameter int unsigned SPEC_B   = 'h000C,
    parameter int unsigned ROM_BASE = 'hC000,
    parameter int unsigned ROM_LAST = 'hEFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                req_we,
    input  logic                req_word,
    input  logic [2*LANE_W-1:0] req_addr,
    input  logic [2*LANE_W-1:0] req_wdata,
    input  logic                req_int,
    input  logic [2*LANE_W-1:0] int_rdata,
    input  logic                width8_pin,
    input  logic                rom16_strap,
    output logic                ale,
    output logic                e_strobe,
    output logic [LANE_W-1:0]   hi_out,
    output logic                hi_oe,
    input  logic [LANE_W-1:0]   hi_in,
    output logic [LANE_W-1:0]   lo_out,
    output logic                lo_oe,
    input  logic [LANE_W-1:0]   lo_in,
    output logic [2*LANE_W-1:0] addr_latched,
    output logic                busy,
    output logic                rd_valid,
    output logic [2*LANE_W-1:0] rd_data
);

    localparam int unsigned AW = 2 * LANE_W;

    logic          start;
    logic [AW-1:0] aligned;
    logic          dec_wide, dec_int, dec_special;
    logic [AW-1:0] addr_q, wdata_q, cur_addr, held;
    logic          we_q, word_q, wide_q, int_q;
    logic          addr_phase, data_phase, second, last_data;

    assign start   = req && !busy;
    assign aligned = req_word ? {req_addr[AW-1:1], 1'b0} : req_addr;

    muxbus_width_decode #(
        .AW(AW), .SPEC_A(SPEC_A), .SPEC_B(SPEC_B),
        .ROM_BASE(ROM_BASE), .ROM_LAST(ROM_LAST)
    ) u_decode (
        .addr        (aligned),
        .width8_pin  (width8_pin),
        .rom16_strap (rom16_strap),
        .int_flag    (req_int),
        .wide        (dec_wide),
        .internal    (dec_int),
        .special     (dec_special)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            word_q  <= 1'b0;
            wide_q  <= 1'b1;
            int_q   <= 1'b0;
        end else if (start) begin
            addr_q  <= aligned;
            wdata_q <= req_wdata;
            we_q    <= req_we;
            word_q  <= req_word;
            wide_q  <= dec_wide;
            int_q   <= dec_int;
        end
    end

    muxbus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .two_beat   (word_q && !wide_q),
        .ale        (ale),
        .e_strobe   (e_strobe),
        .busy       (busy),
        .addr_phase (addr_phase),
        .data_phase (data_phase),
        .second     (second),
        .last_data  (last_data)
    );

    muxbus_lane_steer #(.LANE_W(LANE_W)) u_steer (
        .addr_phase (addr_phase),
        .data_phase (data_phase),
        .second     (second),
        .we         (we_q),
        .word       (word_q),
        .wide       (wide_q),
        .addr       (addr_q),
        .wdata      (wdata_q),
        .cur_addr   (cur_addr),
        .hi_out     (hi_out),
        .hi_oe      (hi_oe),
        .lo_out     (lo_out),
        .lo_oe      (lo_oe)
    );

    muxbus_rd_capture #(.LANE_W(LANE_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (data_phase && !we_q),
        .finish     (last_data && !we_q),
        .second     (second),
        .word       (word_q),
        .wide       (wide_q),
        .internal   (int_q),
        .odd        (cur_addr[0]),
        .hi_in      (hi_in),
        .lo_in      (lo_in),
        .int_rdata  (int_rdata),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    // address latch model: transparent while ale, holding otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)   held <= '0;
        else if (ale) held <= {hi_out, lo_out};
    end
    assign addr_latched = ale ? {hi_out, lo_out} : held;

    assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && !$past(ale)) |-> $stable(addr_latched));

    assert_read_lanes_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_strobe && !we_q) |-> (!hi_oe && !lo_oe));

    assert_special_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dec_special) |=> (wide_q && int_q));

endmodule

// File: tb/muxbus_steer_bench.sv
module muxbus_steer_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] ROM_BASE = 16'hC000;
    localparam logic [15:0] ROM_LAST = 16'hEFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0, req_word = 1'b0, req_int = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0, int_rdata = '0;
    logic        width8_pin = 1'b0, rom16_strap = 1'b0;
    logic [7:0]  hi_in = '0, lo_in = '0;
    logic        ale, e_strobe, hi_oe, lo_oe, busy, rd_valid;
    logic [7:0]  hi_out, lo_out;
    logic [15:0] addr_latched, rd_data;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    muxbus_steer u_muxbus_steer (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_int(req_int),
        .int_rdata(int_rdata), .width8_pin(width8_pin), .rom16_strap(rom16_strap),
        .ale(ale), .e_strobe(e_strobe), .hi_out(hi_out), .hi_oe(hi_oe), .hi_in(hi_in),
        .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in), .addr_latched(addr_latched),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic pins(input string rq, input string what, input bit xa, input bit xe, input bit xb,
                        input bit xho, input logic [7:0] xh, input bit xlo, input logic [7:0] xl);
        logic [20:0] act, exp;
        act = {ale, e_strobe, busy, hi_oe, lo_oe, hi_oe ? hi_out : 8'h00, lo_oe ? lo_out : 8'h00};
        exp = {xa, xe, xb, xho, xlo, xho ? xh : 8'h00, xlo ? xl : 8'h00};
        chk(rq, what, 32'(act), 32'(exp));
    endtask

    // reference model for one access, stepped cycle by cycle
    task automatic access(input string rq, input bit we, input bit word, input logic [15:0] addr,
                          input logic [15:0] wd, input bit ihit, input logic [15:0] ird,
                          input logic [7:0] hin, input logic [7:0] lin, input logic [7:0] lin2,
                          input bit poke);
        bit special, inrom, wide, intl, ho, lo;
        logic [15:0] a, ca, exp_rd;
        logic [7:0] h, l, nb;
        int beats;
        special = (addr[15:1] == 15'h0005) || (addr[15:1] == 15'h0006);
        inrom   = rom16_strap && (addr >= ROM_BASE) && (addr <= ROM_LAST);
        wide    = !width8_pin || special || inrom;
        intl    = ihit || special;
        a       = word ? {addr[15:1], 1'b0} : addr;
        beats   = (word && !wide) ? 2 : 1;
        ca      = a;
        req = 1'b1; req_we = we; req_word = word; req_addr = addr; req_wdata = wd;
        req_int = ihit; int_rdata = ird; hi_in = hin; lo_in = lin;
        for (int b = 0; b < beats; b++) begin
            ca = (b == 1) ? (a | 16'h0001) : a;
            @(negedge clk);
            req = poke && (b == 0);
            if (poke) begin req_addr = 16'hFFFF; req_wdata = 16'h0BAD; req_we = ~we; end
            if (b == 1) lo_in = lin2;
            pins(rq, "address phase", 1, 1, 1, 1, ca[15:8], 1, ca[7:0]);
            chk("R3", "latch transparent", 32'(addr_latched), 32'(ca));
            @(negedge clk);
            req = 1'b0;
            ho = 0; lo = 0; h = 0; l = 0;
            if (we) begin
                if (wide) begin
                    if (word) begin ho = 1; h = wd[15:8]; lo = 1; l = wd[7:0]; end
                    else if (a[0]) begin ho = 1; h = wd[7:0]; end
                    else begin lo = 1; l = wd[7:0]; end
                end else begin
                    nb = (word && b == 1) ? wd[15:8] : wd[7:0];
                    lo = 1; l = nb;
                    if (ca[0]) begin ho = 1; h = nb; end
                end
            end
            pins(rq, "data phase", 0, 0, 1, ho, h, lo, l);
            chk("R3", "latch holds in data phase", 32'(addr_latched), 32'(ca));
        end
        @(negedge clk);
        pins(rq, "back to idle", 0, 1, 0, 0, 8'h00, 0, 8'h00);
        chk("R3", "latch holds in idle", 32'(addr_latched), 32'(ca));
        chk(rq, "rd_valid", 32'(rd_valid), 32'(!we));
        if (!we) begin
            if (wide && word)  exp_rd = intl ? ird : {hin, lin};
            else if (wide)     exp_rd = {8'h00, a[0] ? (intl ? ird[15:8] : hin) : (intl ? ird[7:0] : lin)};
            else if (!word)    exp_rd = {8'h00, intl ? (a[0] ? ird[15:8] : ird[7:0]) : lin};
            else               exp_rd = intl ? ird : {lin2, lin};
            chk(rq, "rd_data", 32'(rd_data), 32'(exp_rd));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        pins("R1", "in reset", 0, 1, 0, 0, 8'h00, 0, 8'h00);
        chk("R1", "rd_valid in reset", 32'(rd_valid), 32'd0);
        chk("R1", "latch in reset", 32'(addr_latched), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        pins("R1", "after reset", 0, 1, 0, 0, 8'h00, 0, 8'h00);

        // 16-bit bus
        width8_pin = 1'b0; rom16_strap = 1'b0;
        access("R4", 1, 1, 16'h1234, 16'hA55A, 0, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        access("R4", 1, 0, 16'h2001, 16'h00C3, 0, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        access("R4", 1, 0, 16'h2002, 16'h003C, 0, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        access("R7", 0, 1, 16'h3000, 16'h0, 0, 16'h0, 8'h9E, 8'h71, 8'h00, 0);
        access("R7", 0, 0, 16'h3005, 16'h0, 0, 16'h0, 8'h44, 8'h88, 8'h00, 0);
        access("R7", 0, 0, 16'h3006, 16'h0, 0, 16'h0, 8'h44, 8'h88, 8'h00, 0);
        access("R11", 0, 1, 16'h3003, 16'h0, 0, 16'h0, 8'h12, 8'h34, 8'h00, 0);
        access("R8", 0, 1, 16'h0400, 16'h0, 1, 16'hBEEF, 8'h11, 8'h22, 8'h00, 0);
        access("R2", 1, 1, 16'h6100, 16'h1357, 0, 16'h0, 8'h00, 8'h00, 8'h00, 1);

        // 8-bit bus
        width8_pin = 1'b1;
        access("R5", 1, 0, 16'h4005, 16'h00E7, 0, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        access("R5", 1, 0, 16'h4006, 16'h007E, 0, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        access("R6", 1, 1, 16'h5000, 16'hCAFE, 0, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        access("R6", 0, 1, 16'h5010, 16'h0, 0, 16'h0, 8'h99, 8'h5A, 8'hA6, 0);
        access("R7", 0, 0, 16'h5021, 16'h0, 0, 16'h0, 8'h99, 8'h3D, 8'h00, 0);
        access("R8", 0, 0, 16'h0101, 16'h0, 1, 16'hD00D, 8'h01, 8'h02, 8'h00, 0);
        access("R8", 0, 1, 16'h0200, 16'h0, 1, 16'h7E57, 8'h01, 8'h02, 8'h03, 0);
        access("R9", 0, 1, 16'h000A, 16'h0, 0, 16'h6B2C, 8'h0F, 8'hF0, 8'h00, 0);
        access("R9", 0, 0, 16'h000D, 16'h0, 0, 16'h81C4, 8'h0F, 8'hF0, 8'h00, 0);
        access("R9", 1, 1, 16'h000C, 16'h2468, 0, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        rom16_strap = 1'b1;
        access("R10", 0, 1, 16'hC100, 16'h0, 0, 16'h0, 8'hAB, 8'hCD, 8'h00, 0);
        access("R10", 1, 1, 16'hEFFE, 16'h1F2E, 0, 16'h0, 8'h00, 8'h00, 8'h00, 0);
        access("R10", 0, 1, 16'hF000, 16'h0, 0, 16'h0, 8'hAB, 8'h61, 8'h62, 0);
        rom16_strap = 1'b0;
        access("R10", 0, 1, 16'hC100, 16'h0, 0, 16'h0, 8'hAB, 8'h71, 8'h72, 0);
        access("R2", 0, 0, 16'h7001, 16'h0, 0, 16'h0, 8'h00, 8'h5C, 8'h00, 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule